// File: doc/BRIEF.md
# Multi-Port Receive Transfer Valid Controller

This block sits on the physical-layer side of a shared receive bus that serves several ports. A link-layer device reads from it by driving an active-low read enable and a 5-bit port address. Both are sampled on the receive FIFO clock. The controller works out which of its ports is being addressed. It pulls words from that port's first-word-fall-through receive FIFO and places each word on the shared bus with a qualifying valid flag. Each word carries its data, start and end markers, byte modulo, parity and error bits.

A transfer from a port stops in two cases: the port's FIFO runs dry, or a word flagged as end of packet has gone out. After a stop, the valid flag stays low and nothing more is pulled until the link deselects the port and selects it again. A port is selected on a clock edge when read enable was deasserted at the previous edge. Every output also has an enable, so the bus can be released. The enable is low whenever read enable is deasserted. It is also low when the selected address is the null address or any address outside this device's window. The FIFO storage and the parity generation live outside this block.

Top module: `rx_valid_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, rx_valid and rx_oe are low and no fifo_pop bit is set. No port is selected until a selection edge occurs.
- R2: A clock edge is a selection edge when rd_en_n was sampled high at the previous edge. At a selection edge, port_addr is sampled. An address in BASE_ADDR to BASE_ADDR+NUM_PORTS-1 selects port index (address − BASE_ADDR). Any other address selects nothing. A selection edge also clears any earlier stop.
- R3: After each edge, rx_oe is high exactly when rd_en_n was low at that edge and a port is selected after that edge. An address of 5'h1F, an address outside the window, or rd_en_n high at the edge gives rx_oe low.
- R4: fifo_pop[i] is high, in the same cycle, only when all of the following hold: port i is selected, rd_en_n is low, the edge is not a selection edge, the port is not stopped, and fifo_empty[i] is low. At most one fifo_pop bit is high at a time.
- R5: rx_valid is high in the cycle after an edge at which a word was popped, and low otherwise. While rx_valid is high, {rx_err, rx_par, rx_mod, rx_eop, rx_sop, rx_data} equal the popped port's head fields at that edge. rx_oe is then high.
- R6: Suppose a pop would be allowed at an edge, but the selected FIFO is empty. The port then becomes stopped, and no further pop occurs until the next selection edge, even if the FIFO refills.
- R7: After a word with its end-of-packet bit set is popped, the port is stopped, and no further pop occurs until the next selection edge.
- R8: A change of port_addr at an edge where rd_en_n stays low and the edge is not a selection edge has no effect on the selected port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive FIFO clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_n | input | 1 | Active-low read enable from the link |
| port_addr | input | ADDR_W | Port address from the link |
| fifo_empty | input | NUM_PORTS | Empty flag of each port's receive FIFO |
| fifo_data | input | NUM_PORTS*DATA_W | Head data word of each FIFO |
| fifo_sop | input | NUM_PORTS | Head start-of-packet flag |
| fifo_eop | input | NUM_PORTS | Head end-of-packet flag |
| fifo_mod | input | NUM_PORTS*MOD_W | Head byte modulo |
| fifo_par | input | NUM_PORTS | Head parity bit |
| fifo_err | input | NUM_PORTS | Head error flag |
| fifo_pop | output | NUM_PORTS | Read strobe, one per FIFO |
| rx_valid | output | 1 | Bus word qualifier |
| rx_data | output | DATA_W | Bus data |
| rx_sop | output | 1 | Bus start of packet |
| rx_eop | output | 1 | Bus end of packet |
| rx_mod | output | MOD_W | Bus byte modulo |
| rx_par | output | 1 | Bus parity |
| rx_err | output | 1 | Bus error flag |
| rx_oe | output | 1 | Output enable for all bus outputs |

## Verification
Two stop conditions can fall on the same edge. The last word of a packet both carries end of packet and leaves its FIFO empty. Separately, a selection edge can coincide with a FIFO refilling after an empty stop. The bench provokes both cases directly, by loading packets whose final word drains the queue and by pushing new words while the port is stopped. A random phase then mixes pauses, null and out-of-window addresses, and pushes in the same cycles. A behavioural model built on per-port queues judges every cycle. It predicts the strobe before the edge, and the valid flag, enable and word fields after it.

// File: rtl/rxv_pkg.sv
package rxv_pkg;

  // Width of the byte modulo field for a given data width.
  function automatic int mod_width(input int data_w);
    int lanes;
    lanes = data_w / 8;
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction

  // Width of a port index.
  function automatic int idx_width(input int ports);
    return (ports > 1) ? $clog2(ports) : 1;
  endfunction

  // Transfer state of the selected port.
  typedef enum logic [1:0] {
    XFER_IDLE    = 2'd0,
    XFER_ACTIVE  = 2'd1,
    XFER_STOPPED = 2'd2
  } xfer_state_e;

endpackage

// File: rtl/rxv_addr_decode.sv
module rxv_addr_decode #(
  parameter int ADDR_W    = 5,
  parameter int NUM_PORTS = 4,
  parameter int BASE_ADDR = 4,
  parameter int NULL_ADDR = 31,
  parameter int IDX_W     = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W:0] LO_BOUND = (ADDR_W+1)'(BASE_ADDR);
  localparam logic [ADDR_W:0] HI_BOUND = (ADDR_W+1)'(BASE_ADDR + NUM_PORTS);
  localparam logic [ADDR_W-1:0] NULL_V = ADDR_W'(NULL_ADDR);
  localparam logic [IDX_W-1:0]  LO_IDX = IDX_W'(BASE_ADDR);

  logic [ADDR_W:0] addr_ext;
  logic            in_window;
  logic            is_null;

  always_comb begin
    addr_ext  = {1'b0, addr};
    in_window = (addr_ext >= LO_BOUND) && (addr_ext < HI_BOUND);
    is_null   = (addr == NULL_V);
    hit       = in_window && !is_null;
    idx       = addr[IDX_W-1:0] - LO_IDX;
  end

endmodule

// File: rtl/rxv_port_mux.sv
module rxv_port_mux #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 16,
  parameter int MOD_W     = 1,
  parameter int IDX_W     = 2,
  parameter int WORD_W    = DATA_W + MOD_W + 4
) (
  input  logic [IDX_W-1:0]           sel_idx,
  input  logic [NUM_PORTS-1:0]       fifo_empty,
  input  logic [NUM_PORTS*DATA_W-1:0] fifo_data,
  input  logic [NUM_PORTS-1:0]       fifo_sop,
  input  logic [NUM_PORTS-1:0]       fifo_eop,
  input  logic [NUM_PORTS*MOD_W-1:0] fifo_mod,
  input  logic [NUM_PORTS-1:0]       fifo_par,
  input  logic [NUM_PORTS-1:0]       fifo_err,
  output logic [WORD_W-1:0]          head_word,
  output logic                       head_empty,
  output logic                       head_eop
);

  // Packed head word layout: {err, par, mod, eop, sop, data}
  localparam int EOP_POS = DATA_W + 1;
  localparam int SLOTS   = 1 << IDX_W;

  logic [WORD_W-1:0] words [SLOTS];
  logic              empt  [SLOTS];

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    if (gi < NUM_PORTS) begin : g_real
      assign words[gi] = {fifo_err[gi], fifo_par[gi],
                          fifo_mod[gi*MOD_W +: MOD_W],
                          fifo_eop[gi], fifo_sop[gi],
                          fifo_data[gi*DATA_W +: DATA_W]};
      assign empt[gi]  = fifo_empty[gi];
    end else begin : g_pad
      assign words[gi] = '0;
      assign empt[gi]  = 1'b1;
    end
  end

  always_comb begin
    head_word  = words[sel_idx];
    head_empty = empt[sel_idx];
    head_eop   = head_word[EOP_POS];
  end

endmodule

// File: rtl/rxv_sel_ctrl.sv
module rxv_sel_ctrl
  import rxv_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en_n,
  input  logic             addr_hit,
  input  logic [IDX_W-1:0] addr_idx,
  input  logic             head_empty,
  input  logic             head_eop,
  output logic [IDX_W-1:0] sel_idx,
  output logic             pop,
  output logic             oe_next
);

  logic        ren_q;      // read enable (active low) at the previous edge
  xfer_state_e state;
  logic        eligible;
  logic        sel_edge;

  always_comb begin
    sel_edge = ren_q;
    eligible = !sel_edge && !rd_en_n && (state == XFER_ACTIVE);
    pop      = eligible && !head_empty;
    if (sel_edge) oe_next = !rd_en_n && addr_hit;
    else          oe_next = !rd_en_n && (state != XFER_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ren_q   <= 1'b1;
      state   <= XFER_IDLE;
      sel_idx <= '0;
    end else begin
      ren_q <= rd_en_n;
      if (sel_edge) begin
        state   <= addr_hit ? XFER_ACTIVE : XFER_IDLE;
        sel_idx <= addr_idx;
      end else if (eligible && (head_empty || head_eop)) begin
        state <= XFER_STOPPED;
      end
    end
  end

endmodule

// File: rtl/rxv_out_reg.sv
module rxv_out_reg #(
  parameter int DATA_W = 16,
  parameter int MOD_W  = 1,
  parameter int WORD_W = DATA_W + MOD_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pop,
  input  logic              oe_next,
  input  logic [WORD_W-1:0] head_word,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_sop,
  output logic              rx_eop,
  output logic [MOD_W-1:0]  rx_mod,
  output logic              rx_par,
  output logic              rx_err,
  output logic              rx_oe
);

  localparam int SOP_POS = DATA_W;
  localparam int EOP_POS = DATA_W + 1;
  localparam int MOD_LSB = DATA_W + 2;
  localparam int PAR_POS = DATA_W + MOD_W + 2;
  localparam int ERR_POS = DATA_W + MOD_W + 3;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid <= 1'b0;
      rx_oe    <= 1'b0;
    end else begin
      rx_valid <= pop;
      rx_oe    <= oe_next;
    end
  end

  // Payload registers carry no reset: qualified by rx_valid.
  always_ff @(posedge clk) begin
    if (pop) begin
      rx_data <= head_word[DATA_W-1:0];
      rx_sop  <= head_word[SOP_POS];
      rx_eop  <= head_word[EOP_POS];
      rx_mod  <= head_word[MOD_LSB +: MOD_W];
      rx_par  <= head_word[PAR_POS];
      rx_err  <= head_word[ERR_POS];
    end
  end

endmodule

// File: rtl/rx_valid_ctrl.sv
module rx_valid_ctrl
  import rxv_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 5,
  parameter int BASE_ADDR = 4,
  parameter int NULL_ADDR = 31,
  localparam int MOD_W    = mod_width(DATA_W)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en_n,
  input  logic [ADDR_W-1:0]           port_addr,
  input  logic [NUM_PORTS-1:0]        fifo_empty,
  input  logic [NUM_PORTS*DATA_W-1:0] fifo_data,
  input  logic [NUM_PORTS-1:0]        fifo_sop,
  input  logic [NUM_PORTS-1:0]        fifo_eop,
  input  logic [NUM_PORTS*MOD_W-1:0]  fifo_mod,
  input  logic [NUM_PORTS-1:0]        fifo_par,
  input  logic [NUM_PORTS-1:0]        fifo_err,
  output logic [NUM_PORTS-1:0]        fifo_pop,
  output logic                        rx_valid,
  output logic [DATA_W-1:0]           rx_data,
  output logic                        rx_sop,
  output logic                        rx_eop,
  output logic [MOD_W-1:0]            rx_mod,
  output logic                        rx_par,
  output logic                        rx_err,
  output logic                        rx_oe
);

  localparam int IDX_W  = idx_width(NUM_PORTS);
  localparam int WORD_W = DATA_W + MOD_W + 4;

  logic              addr_hit;
  logic [IDX_W-1:0]  addr_idx;
  logic [IDX_W-1:0]  sel_idx;
  logic [WORD_W-1:0] head_word;
  logic              head_empty;
  logic              head_eop;
  logic              pop;
  logic              oe_next;

  rxv_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .BASE_ADDR(BASE_ADDR),
    .NULL_ADDR(NULL_ADDR), .IDX_W(IDX_W)
  ) u_dec (
    .addr(port_addr), .hit(addr_hit), .idx(addr_idx)
  );

  rxv_sel_ctrl #(.IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst(rst), .rd_en_n(rd_en_n),
    .addr_hit(addr_hit), .addr_idx(addr_idx),
    .head_empty(head_empty), .head_eop(head_eop),
    .sel_idx(sel_idx), .pop(pop), .oe_next(oe_next)
  );

  rxv_port_mux #(
    .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .MOD_W(MOD_W),
    .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) u_mux (
    .sel_idx(sel_idx), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_sop(fifo_sop), .fifo_eop(fifo_eop), .fifo_mod(fifo_mod),
    .fifo_par(fifo_par), .fifo_err(fifo_err),
    .head_word(head_word), .head_empty(head_empty), .head_eop(head_eop)
  );

  rxv_out_reg #(.DATA_W(DATA_W), .MOD_W(MOD_W), .WORD_W(WORD_W)) u_out (
    .clk(clk), .rst(rst), .pop(pop), .oe_next(oe_next),
    .head_word(head_word),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .rx_mod(rx_mod), .rx_par(rx_par),
    .rx_err(rx_err), .rx_oe(rx_oe)
  );

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_pop
    assign fifo_pop[gp] = pop && (sel_idx == IDX_W'(gp));
  end

endmodule

// File: rtl/rxv_chk.sv
module rxv_chk #(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_en_n,
  input logic [NUM_PORTS-1:0] fifo_empty,
  input logic [NUM_PORTS-1:0] fifo_eop,
  input logic [NUM_PORTS-1:0] fifo_pop,
  input logic                 rx_valid,
  input logic                 rx_oe
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rx_valid && !rx_oe));

  // R4
  pop_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fifo_pop));

  // R4
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_pop & fifo_empty) == '0);

  // R4
  pop_needs_ren_chk: assert property (@(posedge clk) disable iff (rst)
    (|fifo_pop) |-> !rd_en_n);

  // R5
  valid_after_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (|fifo_pop) |=> rx_valid);

  // R5
  no_valid_wo_pop_chk: assert property (@(posedge clk) disable iff (rst)
    !(|fifo_pop) |=> !rx_valid);

  // R5
  valid_drives_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> rx_oe);

  // R3
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en_n |=> !rx_oe);

  // R7
  eop_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (|(fifo_pop & fifo_eop)) |=> !(|fifo_pop));

endmodule

bind rx_valid_ctrl rxv_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk(clk), .rst(rst), .rd_en_n(rd_en_n), .fifo_empty(fifo_empty),
  .fifo_eop(fifo_eop), .fifo_pop(fifo_pop), .rx_valid(rx_valid),
  .rx_oe(rx_oe)
);

// File: tb/rx_valid_ctrl_tb.sv
module rx_valid_ctrl_tb;

  localparam int NP   = 4;
  localparam int DW   = 16;
  localparam int BASE = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst;
  logic            rd_en_n;
  logic [4:0]      port_addr;
  logic [NP-1:0]   fifo_empty, fifo_sop, fifo_eop, fifo_par, fifo_err, fifo_mod;
  logic [NP*DW-1:0] fifo_data;
  logic [NP-1:0]   fifo_pop;
  logic            rx_valid, rx_sop, rx_eop, rx_par, rx_err, rx_oe;
  logic [0:0]      rx_mod;
  logic [DW-1:0]   rx_data;

  rx_valid_ctrl #(.NUM_PORTS(NP), .DATA_W(DW), .ADDR_W(5), .BASE_ADDR(BASE)) u_dut (
    .clk(clk), .rst(rst), .rd_en_n(rd_en_n), .port_addr(port_addr),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_sop(fifo_sop),
    .fifo_eop(fifo_eop), .fifo_mod(fifo_mod), .fifo_par(fifo_par),
    .fifo_err(fifo_err), .fifo_pop(fifo_pop), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_mod(rx_mod),
    .rx_par(rx_par), .rx_err(rx_err), .rx_oe(rx_oe)
  );

  // Entry layout: [15:0] data, 16 sop, 17 eop, 18 mod, 19 par, 20 err
  logic [20:0] fq [NP][$];

  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 0;
  string cur     = "R1 reset";

  int          m_sel;
  bit          m_renq, m_stop, m_valid, m_oe;
  logic [20:0] m_word;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", tag, cur, what, act, exp);
    end
  endtask

  task automatic push(input int p, input logic [15:0] d, input bit s,
                      input bit e, input bit er);
    fq[p].push_back({er, ^d, d[3], e, s, d});
  endtask

  task automatic push_pkt(input int p, input int n, input int seed);
    for (int i = 0; i < n; i++)
      push(p, 16'(seed * 64 + i * 5 + p), i == 0, i == n - 1, (seed % 3) == 0);
  endtask

  function automatic bit in_win(input int a);
    return (a != 31) && (a >= BASE) && (a < BASE + NP);
  endfunction

  task automatic drive_heads();
    for (int p = 0; p < NP; p++) begin
      if (fq[p].size() > 0) begin
        fifo_empty[p]         = 1'b0;
        fifo_data[p*DW +: DW] = fq[p][0][15:0];
        fifo_sop[p]           = fq[p][0][16];
        fifo_eop[p]           = fq[p][0][17];
        fifo_mod[p]           = fq[p][0][18];
        fifo_par[p]           = fq[p][0][19];
        fifo_err[p]           = fq[p][0][20];
      end else begin
        fifo_empty[p]         = 1'b1;
        fifo_data[p*DW +: DW] = 16'hBAD0 | 16'(p);
        fifo_sop[p]           = 1'b1;
        fifo_eop[p]           = 1'b1;
        fifo_mod[p]           = 1'b1;
        fifo_par[p]           = 1'b1;
        fifo_err[p]           = 1'b1;
      end
    end
  endtask

  task automatic cyc(input bit ren, input logic [4:0] a);
    int  exp_pop;
    bit  elig;
    logic [NP-1:0] exp_vec;
    @(negedge clk);
    rd_en_n   = ren;
    port_addr = a;
    drive_heads();
    #1;
    elig    = !m_renq && !ren && (m_sel >= 0) && !m_stop;
    exp_pop = -1;
    if (elig && fq[m_sel].size() > 0) exp_pop = m_sel;
    exp_vec = (exp_pop >= 0) ? NP'(1 << exp_pop) : '0;
    chk(fifo_pop === exp_vec, "R4", "fifo_pop", fifo_pop, exp_vec);
    @(posedge clk);
    m_valid = (exp_pop >= 0);
    if (m_valid) begin
      m_word = fq[exp_pop].pop_front();
      if (m_word[17]) m_stop = 1;      // R7 end of packet
    end else if (elig) begin
      m_stop = 1;                      // R6 empty
    end
    if (m_renq) begin                  // R2 selection edge
      m_sel  = in_win(a) ? int'(a) - BASE : -1;
      m_stop = 0;
    end
    m_oe   = !ren && (m_sel >= 0);
    m_renq = ren;
    #1;
    chk(rx_valid === m_valid, "R5", "rx_valid", rx_valid, m_valid);
    chk(rx_oe === m_oe, "R3", "rx_oe", rx_oe, m_oe);
    if (m_valid)
      chk({rx_err, rx_par, rx_mod, rx_eop, rx_sop, rx_data} === m_word,
          "R5", "bus word", {rx_err, rx_par, rx_mod, rx_eop, rx_sop, rx_data}, m_word);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rd_en_n = 1'b1; port_addr = 5'h1F;
    drive_heads();
    m_sel = -1; m_renq = 1; m_stop = 0; m_valid = 0; m_oe = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(rx_valid === 1'b0, "R1", "rx_valid in reset", rx_valid, 0);
    chk(rx_oe === 1'b0, "R1", "rx_oe in reset", rx_oe, 0);
    chk(fifo_pop === '0, "R1", "fifo_pop in reset", fifo_pop, 0);
    @(negedge clk); rst = 1'b0;
    cyc(1, 5'h1F);

    cur = "R2 R7 select port 1 packet";
    push_pkt(1, 3, 1);
    cyc(1, 5); cyc(0, 5);
    repeat (5) cyc(0, 5);

    cur = "R8 address ignored while enabled";
    push_pkt(2, 4, 2);
    cyc(1, 6); cyc(0, 6);
    cyc(0, 9); cyc(0, 5); cyc(0, 31); cyc(0, 7); cyc(0, 7);

    cur = "R6 empty stop and refill";
    push(3, 16'h1234, 1, 0, 0); push(3, 16'h5678, 0, 0, 0);
    cyc(1, 7); cyc(0, 7); cyc(0, 7); cyc(0, 7); cyc(0, 7);
    push(3, 16'h9ABC, 0, 0, 1); push(3, 16'hDEF0, 0, 1, 0);
    repeat (3) cyc(0, 7);
    cyc(1, 7); cyc(0, 7);
    repeat (3) cyc(0, 7);

    cur = "R7 R6 eop word drains fifo";
    push(0, 16'h00AA, 1, 1, 0);
    cyc(1, 4); cyc(0, 4); cyc(0, 4);
    push_pkt(0, 2, 5);
    cyc(0, 4); cyc(0, 4);

    cur = "R3 null and out-of-window addresses";
    push_pkt(1, 2, 7);
    cyc(1, 5'h1F); cyc(0, 5'h1F); cyc(0, 5);
    cyc(1, 2); cyc(0, 2); cyc(0, 2);
    cyc(1, 8); cyc(0, 8); cyc(0, 8);
    cyc(1, 5); cyc(0, 5); cyc(1, 5); cyc(0, 5); cyc(0, 5); cyc(0, 5);

    cur = "R2 R3 R4 R5 R6 R7 R8 random mix";
    for (int n = 0; n < 600; n++) begin
      int pick;
      logic [4:0] addr;
      pick = int'($urandom % 8);
      case (pick)
        0: addr = 5'd4; 1: addr = 5'd5; 2: addr = 5'd6; 3: addr = 5'd7;
        4: addr = 5'd8; 5: addr = 5'd3; 6: addr = 5'h1F; default: addr = 5'd5;
      endcase
      if (($urandom % 3) == 0) begin
        int p;
        p = int'($urandom % NP);
        if (fq[p].size() < 12) push_pkt(p, 1 + int'($urandom % 4), n);
      end
      cyc(($urandom % 4) == 0, addr);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule